// File: doc/BRIEF.md
# Miss-Proportional Cache Bank Allocator

This block is the decision engine of the corner memory controller that acts as coordinator for redistributing shared second-level cache banks among concurrently running applications. From a run-start pulse it keeps one external-miss counter per application and tracks elapsed cycles. The point of redistribution is set as a fraction of an expected run length. When that point is reached, the block raises a request to the three other corner controllers and accepts one report of per-application miss counts from each. It adds these reports to its own counts and works out how many banks each application should own.

Every application keeps one bank. The remaining banks are shared out in proportion to each application's part of the combined misses. Banks left over after rounding go to the applications with the most misses. Banks are then handed out one per cycle, in rotating turns that start with the neediest application. For each bank the block prefers a free bank that lies next to the receiving cluster, using a neighbour mask supplied from outside. A one-cycle done pulse closes the sequence. Each run performs exactly one redistribution.

Top module: `bank_quota_alloc`

## Requirements
- R1: After reset, `collect_req`, `asg_valid` and `done` are low and stay low until a `run_start` pulse is followed by a trigger.
- R2: A `run_start` pulse clears all counters. After it, every cycle with `miss_valid` high adds one to the counter of application `miss_app`. A counter stops at 2^CNT_W-1.
- R3: `frac_sel` selects a percentage of `expected_cycles`: 0 gives 10, 1 gives 25, 2 gives 50 and 3 gives 75. Counting the edge that takes `run_start` as edge 0, N is the smallest value with N*100 >= expected_cycles*percent. `collect_req` is low after edge N and high after edge N+1.
- R4: While `collect_req` is high, each peer's first `peer_valid` report is added per application to the local counts. Peer p, application a sits at `peer_counts[(p*NUM_APPS+a)*CNT_W +: CNT_W]`. Repeat reports, and reports sent while `collect_req` is low, are ignored. No assignment is issued during collection.
- R5: Collection ends once all peers have reported, or after PEER_TMO cycles. A peer that has not reported adds zero.
- R6: Let c be the combined counts and S their sum. Application a receives 1 + floor((NUM_BANKS-NUM_APPS)*c[a]/S) banks. If S is 0, it receives 1 + (NUM_BANKS-NUM_APPS)/NUM_APPS. The quotas always add up to NUM_BANKS.
- R7: The leftover banks, NUM_BANKS minus the sum of the R6 quotas, go one each to the applications ranked first by count. Ranking is by descending count, and equal counts rank the lower index first.
- R8: Assignment takes turns through the R7 ranking, starting at rank 0. Each turn goes to the next application at or after the turn position that still has quota left. The turn then moves to the position after it.
- R9: The bank given out is the lowest-index free bank whose bit is set in `nbr_mask[a*NUM_BANKS +: NUM_BANKS]` for the receiving application a. If no such bank is free, it is the lowest-index free bank. Every bank is given out exactly once.
- R10: Exactly NUM_BANKS assignments are issued, on consecutive cycles with `asg_valid` high. `done` is high for one cycle, in the cycle after the last assignment.
- R11: Misses that arrive after the trigger are not counted. After `done`, no further output activity occurs until the next `run_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_start | input | 1 | Start of execution; clears counters and arms the trigger |
| expected_cycles | input | ELAPSED_W | Expected run length in cycles |
| frac_sel | input | 2 | Redistribution point: 10/25/50/75 percent |
| miss_valid | input | 1 | One external access by `miss_app` this cycle |
| miss_app | input | AW | Application issuing the access |
| peer_valid | input | NUM_PEERS | Per-peer report strobe |
| peer_counts | input | NUM_PEERS*NUM_APPS*CNT_W | Per-peer, per-application miss counts |
| nbr_mask | input | NUM_APPS*NUM_BANKS | Per-application preferred (adjacent) banks |
| collect_req | output | 1 | Request for peer reports |
| asg_valid | output | 1 | Assignment command valid |
| asg_app | output | AW | Application receiving the bank |
| asg_bank | output | BW | Bank being assigned |
| done | output | 1 | One-cycle pulse after the last assignment |

## Verification
Several input patterns exercise the allocation. With no misses at all, the result must be an even split. Skewed and tied counts show whether the leftover ranking and its lower-index tie-break are right. Counts that exceed the counter range separate saturating counters from wrapping or unbounded ones. A partial set of peer reports, with a duplicate report and an early report mixed in, separates first-report-only acceptance and the timeout path from plain summation. Random neighbour masks, checked next to empty masks, separate the adjacency preference from the lowest-free fallback. An expected run length of zero checks the immediate-trigger boundary.

// File: rtl/bqa_pkg.sv
package bqa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_COMPUTE = 3'd2,
        ST_ASSIGN  = 3'd3,
        ST_DONE    = 3'd4
    } state_t;

    // Percentage of the expected run at which redistribution fires.
    function automatic logic [6:0] frac_pct(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7'd10;
            2'd1:    return 7'd25;
            2'd2:    return 7'd50;
            default: return 7'd75;
        endcase
    endfunction

endpackage

// File: rtl/bqa_miss_counters.sv
module bqa_miss_counters #(
    parameter int NUM_APPS = 4,
    parameter int CNT_W    = 32,
    parameter int AW       = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      enable,
    input  logic                      miss_valid,
    input  logic [AW-1:0]             miss_app,
    output logic [NUM_APPS*CNT_W-1:0] counts_o
);

    logic [NUM_APPS-1:0][CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (enable && miss_valid) begin
            for (int a = 0; a < NUM_APPS; a++) begin
                if (miss_app == AW'(a) && cnt_q[a] != '1)
                    cnt_d[a] = cnt_q[a] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign counts_o = cnt_q;

    for (genvar g = 0; g < NUM_APPS; g++) begin : g_chk
        // R2: a full counter holds its value
        assert_cnt_saturates_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[g] == '1 && !clear) |=> (cnt_q[g] == '1));
        // R11: nothing moves the counter outside the counting window
        assert_cnt_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable && !clear) |=> $stable(cnt_q[g]));
    end

endmodule

// File: rtl/bqa_quota_calc.sv
module bqa_quota_calc #(
    parameter int NUM_APPS  = 4,
    parameter int NUM_BANKS = 16,
    parameter int CW        = 34,
    parameter int AW        = 2,
    parameter int QW        = 5
) (
    input  logic [NUM_APPS*CW-1:0] totals_i,
    output logic [NUM_APPS*QW-1:0] quota_o,
    output logic [NUM_APPS*AW-1:0] order_o
);

    localparam int SPARE = NUM_BANKS - NUM_APPS;
    localparam int SW    = CW + $clog2(NUM_APPS) + 1;
    localparam int PW    = SW + $clog2(SPARE + 1) + 1;

    logic [NUM_APPS-1:0][CW-1:0] c;
    assign c = totals_i;

    always_comb begin
        logic [SW-1:0] total;
        int share [NUM_APPS];
        int rank  [NUM_APPS];
        int left;
        quota_o = '0;
        order_o = '0;
        total   = '0;
        for (int a = 0; a < NUM_APPS; a++) total = total + SW'(c[a]);
        left = SPARE;
        for (int a = 0; a < NUM_APPS; a++) begin
            share[a] = 0;
            if (total == '0) begin
                share[a] = SPARE / NUM_APPS;
            end else begin
                for (int k = 1; k <= SPARE; k++) begin
                    if (PW'(k) * PW'(total) <= PW'(SPARE) * PW'(c[a]))
                        share[a] = k;
                end
            end
            left = left - share[a];
        end
        for (int a = 0; a < NUM_APPS; a++) begin
            rank[a] = 0;
            for (int j = 0; j < NUM_APPS; j++) begin
                if (c[j] > c[a] || (c[j] == c[a] && j < a))
                    rank[a] = rank[a] + 1;
            end
            quota_o[a*QW +: QW] = QW'(1 + share[a] + ((rank[a] < left) ? 1 : 0));
            order_o[rank[a]*AW +: AW] = AW'(a);
        end
    end

endmodule

// File: rtl/bqa_bank_picker.sv
module bqa_bank_picker #(
    parameter int NUM_BANKS = 16,
    parameter int BW        = 4
) (
    input  logic [NUM_BANKS-1:0] free_i,
    input  logic [NUM_BANKS-1:0] pref_i,
    output logic [BW-1:0]        bank_o,
    output logic                 found_o
);

    logic [NUM_BANKS-1:0] near, pool;

    assign near = free_i & pref_i;
    assign pool = (|near) ? near : free_i;

    always_comb begin
        bank_o  = '0;
        found_o = 1'b0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (pool[b]) begin
                bank_o  = BW'(b);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bank_quota_alloc.sv
module bank_quota_alloc
    import bqa_pkg::*;
#(
    parameter int NUM_APPS  = 4,
    parameter int NUM_BANKS = 16,
    parameter int CNT_W     = 32,
    parameter int NUM_PEERS = 3,
    parameter int PEER_TMO  = 64,
    parameter int ELAPSED_W = 32,
    localparam int AW       = (NUM_APPS > 1) ? $clog2(NUM_APPS) : 1,
    localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                run_start,
    input  logic [ELAPSED_W-1:0]                expected_cycles,
    input  logic [1:0]                          frac_sel,
    input  logic                                miss_valid,
    input  logic [AW-1:0]                       miss_app,
    input  logic [NUM_PEERS-1:0]                peer_valid,
    input  logic [NUM_PEERS*NUM_APPS*CNT_W-1:0] peer_counts,
    input  logic [NUM_APPS*NUM_BANKS-1:0]       nbr_mask,
    output logic                                collect_req,
    output logic                                asg_valid,
    output logic [AW-1:0]                       asg_app,
    output logic [BW-1:0]                       asg_bank,
    output logic                                done
);

    localparam int CMB_W = CNT_W + $clog2(NUM_PEERS + 1);
    localparam int QW    = $clog2(NUM_BANKS + 1);
    localparam int TMW   = $clog2(PEER_TMO + 1);
    localparam int ISW   = $clog2(NUM_BANKS + 1);
    localparam int TRW   = ELAPSED_W + 8;

    typedef struct packed {
        state_t                          state;
        logic                            armed;
        logic [ELAPSED_W-1:0]            elapsed;
        logic [NUM_PEERS-1:0]            got;
        logic [TMW-1:0]                  tmo;
        logic [NUM_APPS-1:0][CMB_W-1:0]  psum;
        logic [NUM_APPS-1:0][QW-1:0]     rem;
        logic [NUM_APPS-1:0][AW-1:0]     order;
        logic [AW-1:0]                   turn;
        logic [NUM_BANKS-1:0]            free;
        logic [ISW-1:0]                  issued;
        logic                            asg_valid;
        logic [AW-1:0]                   asg_app;
        logic [BW-1:0]                   asg_bank;
        logic                            done;
    } regs_t;

    regs_t r_q, r_d;

    // Local per-application counters
    logic [NUM_APPS*CNT_W-1:0] local_flat;
    logic [NUM_APPS-1:0][CNT_W-1:0] local_cnt;
    logic count_en;

    assign count_en = (r_q.state == ST_IDLE) && r_q.armed;

    bqa_miss_counters #(.NUM_APPS(NUM_APPS), .CNT_W(CNT_W), .AW(AW)) u_counters (
        .clk(clk), .rst_n(rst_n), .clear(run_start), .enable(count_en),
        .miss_valid(miss_valid), .miss_app(miss_app), .counts_o(local_flat)
    );
    assign local_cnt = local_flat;

    // Combined totals feed the quota computation
    logic [NUM_APPS-1:0][CMB_W-1:0] totals;
    logic [NUM_APPS*QW-1:0] quota_flat;
    logic [NUM_APPS*AW-1:0] order_flat;

    for (genvar g = 0; g < NUM_APPS; g++) begin : g_tot
        assign totals[g] = CMB_W'(local_cnt[g]) + r_q.psum[g];
    end

    bqa_quota_calc #(.NUM_APPS(NUM_APPS), .NUM_BANKS(NUM_BANKS), .CW(CMB_W), .AW(AW), .QW(QW)) u_quota (
        .totals_i(totals), .quota_o(quota_flat), .order_o(order_flat)
    );

    // Turn selection: first application from the turn position with quota left
    logic [AW-1:0]        sel_pos, sel_app;
    logic                 sel_found;
    logic [NUM_BANKS-1:0] sel_pref;

    always_comb begin
        sel_pos   = '0;
        sel_app   = r_q.order[0];
        sel_found = 1'b0;
        for (int i = 0; i < NUM_APPS; i++) begin
            int p;
            p = int'(r_q.turn) + i;
            if (p >= NUM_APPS) p = p - NUM_APPS;
            if (!sel_found && r_q.rem[r_q.order[p]] != '0) begin
                sel_found = 1'b1;
                sel_pos   = AW'(p);
                sel_app   = r_q.order[p];
            end
        end
        sel_pref = nbr_mask[int'(sel_app)*NUM_BANKS +: NUM_BANKS];
    end

    logic [BW-1:0] pick_bank;
    logic          pick_found;

    bqa_bank_picker #(.NUM_BANKS(NUM_BANKS), .BW(BW)) u_picker (
        .free_i(r_q.free), .pref_i(sel_pref), .bank_o(pick_bank), .found_o(pick_found)
    );

    logic trigger;
    assign trigger = (TRW'(r_q.elapsed) * TRW'(100)) >=
                     (TRW'(expected_cycles) * TRW'(frac_pct(frac_sel)));

    always_comb begin
        r_d           = r_q;
        r_d.asg_valid = 1'b0;
        r_d.done      = 1'b0;
        if (run_start) begin
            r_d.state   = ST_IDLE;
            r_d.armed   = 1'b1;
            r_d.elapsed = '0;
            r_d.got     = '0;
            r_d.tmo     = '0;
            r_d.psum    = '0;
        end else begin
            case (r_q.state)
                ST_IDLE: begin
                    if (r_q.armed) begin
                        if (trigger) begin
                            r_d.state = ST_COLLECT;
                            r_d.armed = 1'b0;
                            r_d.tmo   = '0;
                            r_d.got   = '0;
                        end else if (r_q.elapsed != '1) begin
                            r_d.elapsed = r_q.elapsed + ELAPSED_W'(1);
                        end
                    end
                end
                ST_COLLECT: begin
                    for (int p = 0; p < NUM_PEERS; p++) begin
                        if (peer_valid[p] && !r_q.got[p]) begin
                            r_d.got[p] = 1'b1;
                            for (int a = 0; a < NUM_APPS; a++)
                                r_d.psum[a] = r_d.psum[a] +
                                    CMB_W'(peer_counts[(p*NUM_APPS+a)*CNT_W +: CNT_W]);
                        end
                    end
                    if ((&r_d.got) || r_q.tmo == TMW'(PEER_TMO - 1))
                        r_d.state = ST_COMPUTE;
                    else
                        r_d.tmo = r_q.tmo + TMW'(1);
                end
                ST_COMPUTE: begin
                    for (int a = 0; a < NUM_APPS; a++) begin
                        r_d.rem[a]   = quota_flat[a*QW +: QW];
                        r_d.order[a] = order_flat[a*AW +: AW];
                    end
                    r_d.turn   = '0;
                    r_d.free   = '1;
                    r_d.issued = '0;
                    r_d.state  = ST_ASSIGN;
                end
                ST_ASSIGN: begin
                    if (sel_found && pick_found) begin
                        r_d.asg_valid       = 1'b1;
                        r_d.asg_app         = sel_app;
                        r_d.asg_bank        = pick_bank;
                        r_d.free[pick_bank] = 1'b0;
                        r_d.rem[sel_app]    = r_q.rem[sel_app] - QW'(1);
                        r_d.turn   = (int'(sel_pos) == NUM_APPS - 1) ? '0 : sel_pos + AW'(1);
                        r_d.issued = r_q.issued + ISW'(1);
                        if (r_q.issued == ISW'(NUM_BANKS - 1)) r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_DONE;
                    end
                end
                ST_DONE: begin
                    r_d.done = r_q.asg_valid;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign collect_req = (r_q.state == ST_COLLECT);
    assign asg_valid   = r_q.asg_valid;
    assign asg_app     = r_q.asg_app;
    assign asg_bank    = r_q.asg_bank;
    assign done        = r_q.done;

    // Checks on the loaded quotas
    int   rem_sum;
    logic rem_all_nz;
    always_comb begin
        rem_sum    = 0;
        rem_all_nz = 1'b1;
        for (int a = 0; a < NUM_APPS; a++) begin
            rem_sum = rem_sum + int'(r_q.rem[a]);
            if (r_q.rem[a] == '0) rem_all_nz = 1'b0;
        end
    end

    assert_quota_total_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ASSIGN && r_q.issued == '0) |-> (rem_sum == NUM_BANKS));
    assert_quota_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ASSIGN && r_q.issued == '0) |-> rem_all_nz);
    assert_quiet_collect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        collect_req |-> !asg_valid);
    assert_bank_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        asg_valid |-> !r_q.free[asg_bank]);
    assert_done_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!asg_valid && r_q.issued == ISW'(NUM_BANKS)));

endmodule

// File: tb/bank_quota_alloc_bench.sv
module bank_quota_alloc_bench;

    localparam int NA = 4, NB = 16, CW = 8, NP = 3, TMO = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_start = 1'b0;
    logic [31:0] expected_cycles = '0;
    logic [1:0] frac_sel = '0;
    logic miss_valid = 1'b0;
    logic [1:0] miss_app = '0;
    logic [NP-1:0] peer_valid = '0;
    logic [NP*NA*CW-1:0] peer_counts = '0;
    logic [NA*NB-1:0] nbr_mask = '0;
    logic collect_req, asg_valid, done;
    logic [1:0] asg_app;
    logic [3:0] asg_bank;

    always #5 clk = ~clk;

    bank_quota_alloc #(.NUM_APPS(NA), .NUM_BANKS(NB), .CNT_W(CW), .NUM_PEERS(NP),
                       .PEER_TMO(TMO), .ELAPSED_W(32)) u_bank_quota_alloc (
        .clk(clk), .rst_n(rst_n), .run_start(run_start), .expected_cycles(expected_cycles),
        .frac_sel(frac_sel), .miss_valid(miss_valid), .miss_app(miss_app),
        .peer_valid(peer_valid), .peer_counts(peer_counts), .nbr_mask(nbr_mask),
        .collect_req(collect_req), .asg_valid(asg_valid), .asg_app(asg_app),
        .asg_bank(asg_bank), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int cfg_exp, cfg_fsel, cfg_missp;
    int cfg_w [NA];
    logic [NP-1:0] cfg_resp;
    int cfg_pc [NP][NA];
    logic [NB-1:0] cfg_nbr [NA];
    int m_local [NA];
    int exp_app [NB], exp_bank [NB], exp_quota [NA];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Requirement model: R2 saturation, R4/R5 peer sum, R6 quota, R7 leftover, R8 turns, R9 bank choice
    task automatic build_expect();
        int c [NA];
        int s, left, turn;
        int share [NA], rank [NA], order [NA], rem [NA];
        logic [NB-1:0] freem;
        s = 0;
        for (int a = 0; a < NA; a++) begin
            c[a] = (m_local[a] > 255) ? 255 : m_local[a];
            for (int p = 0; p < NP; p++) if (cfg_resp[p]) c[a] += cfg_pc[p][a];
            s += c[a];
        end
        left = NB - NA;
        for (int a = 0; a < NA; a++) begin
            share[a] = (s == 0) ? (NB - NA) / NA : ((NB - NA) * c[a]) / s;
            left -= share[a];
        end
        for (int a = 0; a < NA; a++) begin
            rank[a] = 0;
            for (int j = 0; j < NA; j++)
                if (c[j] > c[a] || (c[j] == c[a] && j < a)) rank[a]++;
            exp_quota[a] = 1 + share[a] + ((rank[a] < left) ? 1 : 0);
            rem[a] = exp_quota[a];
            order[rank[a]] = a;
        end
        turn = 0;
        freem = '1;
        for (int k = 0; k < NB; k++) begin
            int app, pos, bank;
            app = -1; pos = 0;
            for (int i = 0; i < NA; i++) begin
                int q;
                q = (turn + i) % NA;
                if (app < 0 && rem[order[q]] > 0) begin app = order[q]; pos = q; end
            end
            bank = -1;
            for (int b = 0; b < NB; b++)
                if (bank < 0 && freem[b] && cfg_nbr[app][b]) bank = b;
            for (int b = 0; b < NB; b++)
                if (bank < 0 && freem[b]) bank = b;
            exp_app[k] = app;
            exp_bank[k] = bank;
            freem[bank] = 1'b0;
            rem[app]--;
            turn = (pos + 1) % NA;
        end
    endtask

    function automatic int pick_app();
        int tot, r;
        tot = 0;
        for (int a = 0; a < NA; a++) tot += cfg_w[a];
        if (tot == 0) return 0;
        r = $urandom % tot;
        for (int a = 0; a < NA; a++) begin
            if (r < cfg_w[a]) return a;
            r -= cfg_w[a];
        end
        return NA - 1;
    endfunction

    task automatic run_scenario(input string name);
        int pct [4] = '{10, 25, 50, 75};
        int n, k, cyc, last_cyc, got_app [NA];
        bit done_seen;
        for (int a = 0; a < NA; a++) begin
            m_local[a] = 0;
            got_app[a] = 0;
            nbr_mask[a*NB +: NB] = cfg_nbr[a];
        end
        expected_cycles = cfg_exp;
        frac_sel = 2'(cfg_fsel);
        n = (cfg_exp * pct[cfg_fsel] + 99) / 100;
        @(negedge clk) run_start = 1'b1;
        @(negedge clk) run_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            miss_valid = (($urandom % 100) < cfg_missp);
            miss_app = 2'(pick_app());
            if (miss_valid) m_local[miss_app]++;
            if (i == 0) begin
                peer_valid = '1;                 // R4: too early, must be ignored
                peer_counts = '1;
            end else peer_valid = '0;
            @(negedge clk);
        end
        miss_valid = 1'b0;
        peer_valid = '0;
        chk(collect_req == 1'b0, {"R3 request low at point ", name}, collect_req, 0);
        @(negedge clk);
        chk(collect_req == 1'b1, {"R3 request raised ", name}, collect_req, 1);
        miss_valid = 1'b1;                       // R11: misses after trigger not counted
        miss_app = 2'd3;
        for (int p = 0; p < NP; p++) begin
            if (cfg_resp[p]) begin
                peer_valid = NP'(1) << p;
                for (int a = 0; a < NA; a++) peer_counts[(p*NA+a)*CW +: CW] = CW'(cfg_pc[p][a]);
                @(negedge clk);
                if (p == 0) begin                // R4: repeat report ignored
                    for (int a = 0; a < NA; a++) peer_counts[a*CW +: CW] = 8'd77;
                    @(negedge clk);
                end
            end
        end
        peer_valid = '0;
        miss_valid = 1'b0;
        build_expect();
        k = 0; cyc = 0; last_cyc = -10; done_seen = 0;
        while (!done_seen && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (asg_valid) begin
                if (k < NB) begin
                    chk(int'(asg_app) == exp_app[k], {"R8 turn order ", name}, asg_app, exp_app[k]);
                    chk(int'(asg_bank) == exp_bank[k], {"R9 bank choice ", name}, asg_bank, exp_bank[k]);
                    got_app[asg_app]++;
                end
                k++;
                last_cyc = cyc;
            end
            if (done) begin
                done_seen = 1;
                chk(cyc == last_cyc + 1, {"R10 done after last ", name}, cyc, last_cyc + 1);
            end
        end
        chk(k == NB, {"R10 assignment count ", name}, k, NB);
        for (int a = 0; a < NA; a++)
            chk(got_app[a] == exp_quota[a], {"R6 R7 quota ", name}, got_app[a], exp_quota[a]);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!asg_valid && !done && !collect_req, {"R11 quiet after done ", name},
                {asg_valid, done, collect_req}, 0);
        end
    endtask

    task automatic clear_cfg();
        for (int a = 0; a < NA; a++) begin
            cfg_w[a] = 1;
            cfg_nbr[a] = '0;
            for (int p = 0; p < NP; p++) cfg_pc[p][a] = 0;
        end
        cfg_resp = '0;
        cfg_missp = 0;
        cfg_exp = 100;
        cfg_fsel = 0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!collect_req && !asg_valid && !done, "R1 reset outputs", {collect_req, asg_valid, done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!collect_req && !asg_valid && !done, "R1 idle before start", {collect_req, asg_valid, done}, 0);

        // R3 boundary, R5 timeout, R6 empty-sum split
        clear_cfg();
        cfg_exp = 0;
        run_scenario("zero-run empty");

        // R7 tie break by lower index with leftover banks
        clear_cfg();
        cfg_resp = 3'b001;
        cfg_pc[0] = '{0, 2, 2, 1};
        cfg_fsel = 1;
        run_scenario("ties");

        // R2 saturation: app0 sees 500 misses, limit 255
        clear_cfg();
        cfg_exp = 1000; cfg_fsel = 2; cfg_missp = 100;
        cfg_w = '{1, 0, 0, 0};
        cfg_resp = 3'b010;
        cfg_pc[1] = '{0, 200, 0, 0};
        run_scenario("saturate");

        // R9 neighbour preference
        clear_cfg();
        cfg_resp = 3'b111;
        cfg_pc[0] = '{10, 40, 5, 0};
        cfg_pc[1] = '{3, 0, 9, 1};
        cfg_pc[2] = '{0, 20, 0, 0};
        cfg_nbr[0] = 16'hF000; cfg_nbr[1] = 16'h00F0; cfg_nbr[2] = 16'h0003; cfg_nbr[3] = 16'h8000;
        cfg_exp = 40; cfg_fsel = 3; cfg_missp = 50;
        run_scenario("neighbours");

        for (int t = 0; t < 8; t++) begin
            clear_cfg();
            cfg_exp = 20 + ($urandom % 280);
            cfg_fsel = $urandom % 4;
            cfg_missp = $urandom % 101;
            for (int a = 0; a < NA; a++) begin
                cfg_w[a] = $urandom % 8;
                cfg_nbr[a] = 16'($urandom & $urandom & $urandom);
                for (int p = 0; p < NP; p++) cfg_pc[p][a] = $urandom % 256;
            end
            cfg_resp = 3'($urandom);
            run_scenario($sformatf("random%0d", t));
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule